// File: doc/BRIEF.md
# I2C Target Address Decoder with General-Call Reset

This block is the receive side of an I2C target. It samples SCL and SDA into the system clock domain and finds start, repeated start and stop conditions on the sampled lines. It shifts in each byte and decides whether to acknowledge it. To acknowledge, it pulls SDA low through an open-drain output enable during the ninth clock. The device answers to a fixed 7-bit address whose upper four bits are 1001 and whose lower three bits are a parameter, so the default address is 1001000.

The block also decodes the general-call address 00h. It always acknowledges that address. After it, the block accepts only two command bytes. Command 06h raises a one-cycle reset pulse for the device core. Command 04h raises a separate one-cycle strobe. The block refuses every other command byte.

When a matched read is addressed, the block acknowledges and then leaves SDA released. The master therefore reads a stub byte of FFh. The block then waits for the next start condition.

Top module: `i2c_gc_target`

## Requirements
- R1: An address byte whose upper seven bits equal {1001, ADDR_LOW} is acknowledged: SDA is held low for the whole high phase of the ninth clock.
- R2: An address byte matching neither the own address nor 00h is not acknowledged. Every later byte up to the next start condition is also left unacknowledged.
- R3: Bit 0 of a matching address byte, the last bit received, is captured on rw_o (1 = read, 0 = write). After an acknowledged read address, SDA is never driven for the following byte, so the master reads FFh.
- R4: After a matching write address, every data byte is acknowledged. Its value, including 06h, causes no pulse on either core output.
- R5: The address byte 00h (general call) is always acknowledged.
- R6: After a general call, the data byte 06h is acknowledged. core_rst_o then pulses high for exactly one clock after the ninth clock falls, and the block returns to idle: the next byte before a start is not acknowledged.
- R7: After a general call, the data byte 04h is acknowledged and gc_cmd04_o pulses high for exactly one clock. core_rst_o stays low.
- R8: After a general call, any data byte other than 04h and 06h is not acknowledged and produces no pulse.
- R9: A start condition seen during a transfer restarts address reception at the first bit.
- R10: After a stop condition, bytes clocked without a new start are not acknowledged.
- R11: sda_oe_o changes only while SCL is low, never during a high phase of SCL.
- R12: After reset, sda_oe_o, rw_o, core_rst_o and gc_cmd04_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| rw_o | output | 1 | Read/write bit of the last matching address |
| core_rst_o | output | 1 | One-cycle full reset pulse for the device core |
| gc_cmd04_o | output | 1 | One-cycle strobe for general-call command 04h |

## Verification
The bench drives the decoder with several kinds of first byte and checks the acknowledge each one gets. It uses the own address with read and with write, a neighbouring address, and 00h. These show that the match looks at all seven bits, that the general call is accepted on its own, and that the read flag is captured.

The bytes that follow are chosen to separate the paths. The bench sends 06h both after a write and after a general call, which shows that the reset comes only from general-call context. It also sends 04h and 07h after a general call, which separates the strobe, the reset and a refusal. The bench also issues a repeated start right after a refused address, and clocks a byte after a stop with no new start. These show whether the framing conditions restart or end reception.

// File: rtl/i2c_gc_target.sv
module i2c_gc_target #(
  parameter logic [2:0] ADDR_LOW    = 3'b000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic rw_o,
  output logic core_rst_o,
  output logic gc_cmd04_o
);
  localparam logic [6:0] OWN_ADDR = {4'b1001, ADDR_LOW};
  localparam logic [7:0] GC_RESET = 8'h06;
  localparam logic [7:0] GC_LATCH = 8'h04;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK} state_t;
  typedef enum logic [1:0] {M_WRITE, M_READ, M_GC} mode_t;
  typedef enum logic [1:0] {A_NONE, A_RST, A_CMD04} act_t;

  logic [SYNC_STAGES:0] scl_sh, sda_sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end

  wire scl_s = scl_sh[SYNC_STAGES-1];
  wire scl_d = scl_sh[SYNC_STAGES];
  wire sda_s = sda_sh[SYNC_STAGES-1];
  wire sda_d = sda_sh[SYNC_STAGES];

  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  state_t     state;
  mode_t      mode;
  act_t       act;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       first;

  wire addr_hit = first && (shreg[7:1] == OWN_ADDR);
  wire gc_hit   = first && (shreg == 8'h00);
  wire gc_ok    = !first && (mode == M_GC) && (shreg == GC_RESET || shreg == GC_LATCH);
  wire wr_ok    = !first && (mode == M_WRITE);
  wire ack_now  = addr_hit || gc_hit || gc_ok || wr_ok;

  mode_t mode_nxt;
  act_t  act_nxt;
  always_comb begin
    mode_nxt = mode;
    if (first) mode_nxt = gc_hit ? M_GC : (shreg[0] ? M_READ : M_WRITE);
    act_nxt = A_NONE;
    if (!first && mode == M_GC)
      act_nxt = (shreg == GC_RESET) ? A_RST : (shreg == GC_LATCH) ? A_CMD04 : A_NONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      mode <= M_WRITE;
      act <= A_NONE;
      bitcnt <= '0;
      shreg <= '0;
      first <= 1'b0;
      sda_oe_o <= 1'b0;
      rw_o <= 1'b0;
      core_rst_o <= 1'b0;
      gc_cmd04_o <= 1'b0;
    end else begin
      core_rst_o <= 1'b0;
      gc_cmd04_o <= 1'b0;
      if (start_det) begin
        state <= S_RX;
        bitcnt <= '0;
        first <= 1'b1;
        act <= A_NONE;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          S_RX:
            if (scl_rise && bitcnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              state <= ack_now ? S_ACK : S_IDLE;
              sda_oe_o <= ack_now;
              mode <= mode_nxt;
              act <= act_nxt;
              if (addr_hit) rw_o <= shreg[0];
            end
          S_ACK:
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              bitcnt <= '0;
              first <= 1'b0;
              core_rst_o <= (act == A_RST);
              gc_cmd04_o <= (act == A_CMD04);
              state <= (act != A_NONE || mode == M_READ) ? S_IDLE : S_RX;
            end
          default: ;
        endcase
      end
    end

  assert_oe_edge_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |=> !core_rst_o);
  assert_rst_bus_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> (!sda_oe_o && !scl_s));
  assert_cmd04_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gc_cmd04_o |=> !gc_cmd04_o);
  assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_rst_o && gc_cmd04_o));
  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);
endmodule

// File: tb/i2c_gc_target_tb_top.sv
module i2c_gc_target_tb_top;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, rw, core_rst, cmd04;
  wire  sda_bus = m_sda & ~sda_oe;
  int checks = 0, fails = 0;
  int rst_cnt = 0, c04_cnt = 0, run_len = 0, max_len = 0, r11_bad = 0;
  bit prev_oe = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  i2c_gc_target dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .rw_o(rw), .core_rst_o(core_rst), .gc_cmd04_o(cmd04));

  always @(negedge clk) if (rst_n) begin
    rst_cnt += int'(core_rst);
    c04_cnt += int'(cmd04);
    if (core_rst || cmd04) run_len++; else run_len = 0;
    if (run_len > max_len) max_len = run_len;
    if (scl && sda_oe != prev_oe) r11_bad++;
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(posedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit drove = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); scl = 1'b1; wq();
      @(negedge clk); drove |= sda_oe;
      wq(); scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    @(negedge clk);
    check(sda_bus == !exp_ack, req, int'(!sda_bus), int'(exp_ack));
    check(!drove, "R11 no drive in data bits", int'(drove), 0);
    wq(); scl = 1'b0; wq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({sda_oe, rw, core_rst, cmd04} == 4'b0, "R12 reset state", {sda_oe, rw, core_rst, cmd04}, 0);
    rst_n = 1'b1; wq(2);

    // own write address, data including 06h
    bus_start();
    send_byte(8'h90, 1, "R1 own address write");
    check(rw == 1'b0, "R3 write flag", rw, 0);
    send_byte(8'h5A, 1, "R4 write data");
    send_byte(8'h06, 1, "R4 06h as plain data");
    check(rst_cnt == 0 && c04_cnt == 0, "R4 no pulse on data", rst_cnt + c04_cnt, 0);
    bus_stop();

    // neighbouring address
    bus_start();
    send_byte(8'h92, 0, "R2 foreign address");
    send_byte(8'h00, 0, "R2 later byte ignored");
    bus_stop();

    // read address, stub byte
    bus_start();
    send_byte(8'h91, 1, "R3 own address read");
    check(rw == 1'b1, "R3 read flag", rw, 1);
    send_byte(8'hFF, 0, "R3 stub byte released");
    bus_stop();

    // general call 04h
    bus_start();
    send_byte(8'h00, 1, "R5 general call address");
    send_byte(8'h04, 1, "R7 command 04h");
    check(c04_cnt == 1 && rst_cnt == 0, "R7 strobe only", c04_cnt * 10 + rst_cnt, 10);
    bus_stop();

    // general call 06h
    bus_start();
    send_byte(8'h00, 1, "R5 general call address again");
    send_byte(8'h06, 1, "R6 command 06h");
    check(rst_cnt == 1 && c04_cnt == 1, "R6 reset pulse", rst_cnt * 10 + c04_cnt, 11);
    send_byte(8'h06, 0, "R6 idle after reset");
    check(rst_cnt == 1, "R6 single reset", rst_cnt, 1);
    bus_stop();

    // general call other byte
    bus_start();
    send_byte(8'h00, 1, "R5 general call address third");
    send_byte(8'h07, 0, "R8 refused command");
    check(rst_cnt == 1 && c04_cnt == 1, "R8 no pulse", rst_cnt * 10 + c04_cnt, 11);
    bus_stop();

    // repeated start
    bus_start();
    send_byte(8'h92, 0, "R9 foreign before restart");
    bus_start();
    send_byte(8'h90, 1, "R9 own after repeated start");
    send_byte(8'h11, 1, "R9 data after restart");
    bus_stop();

    // bytes after stop without start
    scl = 1'b0; wq();
    send_byte(8'h90, 0, "R10 no start after stop");
    bus_stop();

    check(max_len == 1, "R6 R7 pulse width", max_len, 1);
    check(r11_bad == 0, "R11 oe change while scl high", r11_bad, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule